// File: doc/BRIEF.md
# Peer Doorbell Register Block

This block is the register face of a device that several peers share. A host reaches it through a simple read/write register bus inside a 1 KB window. The window holds four 32-bit registers: an interrupt mask, an interrupt status, a read-only peer identifier and a write-only doorbell.

A write to the doorbell splits the word into a 16-bit destination peer and a 16-bit vector. The block then emits a one-cycle outbound event that carries both fields. Inbound events from other peers arrive on a separate strobe. What an inbound event does depends on a static interrupt mode input:
- In pin mode it sets the status register, and a level interrupt follows from mask and status.
- In message mode it pulses one bit of a per-vector message-interrupt output and never touches status.

The identifier register reads all ones until the ready input rises. The transport of events between peers, the shared memory itself and configuration space are handled elsewhere.

Top module: `shm_doorbell_regs`

## Requirements
- R1: Register offsets inside the 10-bit byte address are fixed: 0x00 mask, 0x04 status, 0x08 position, 0x0C doorbell. Reading any other offset returns 0, and writing one has no effect. `rdData` is 0 whenever `rdEn` is low. Reads are combinational in the cycle where `rdEn` is high.
- R2: After reset, mask and status read 0, `evOutValid` is 0, `msiPulse` is 0 and `intrLevel` is 0. The mask register holds any 32-bit value that is written to it and reads it back.
- R3: In pin mode (`msiMode` = 0), an inbound event (`evInValid` high at a clock edge) sets status to exactly 1, whatever its vector.
- R4: `intrLevel` is high exactly when `msiMode` is 0 and bit 0 of both mask and status is 1. Mask bits 31:1 have no effect.
- R5: Reading status returns its current value and clears it to 0 at that clock edge. If an inbound pin-mode event arrives at the same edge, status ends at 1. Writes to status are ignored.
- R6: Position reads {16'h0, `localId`} while `devReady` is 1, and 32'hFFFFFFFF while it is 0. Writes to position are ignored.
- R7: A doorbell write that is accepted makes `evOutValid` high for exactly the next cycle. In that cycle `evOutPeer` equals write data bits 31:16 and `evOutVec` equals bits 15:0. The doorbell reads back as 0.
- R8: In pin mode, every doorbell write is accepted, whatever the vector field holds.
- R9: In message mode, a doorbell write whose vector is at or above `NUM_VEC` is dropped, and no outbound event follows.
- R10: In message mode, an inbound event with vector v < `NUM_VEC` makes `msiPulse` equal to one-hot bit v for exactly the next cycle. Vectors at or above `NUM_VEC` are ignored. Status is never changed, and `intrLevel` stays low.
- R11: In pin mode, inbound events never pulse `msiPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiMode | input | 1 | 1 selects message interrupts, 0 selects pin interrupts |
| devReady | input | 1 | Local identifier is valid |
| localId | input | 16 | Local peer identifier |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 10 | Byte address in the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| evInValid | input | 1 | Inbound event strobe |
| evInVec | input | 16 | Inbound event vector |
| evOutValid | output | 1 | Outbound event strobe, one cycle |
| evOutPeer | output | 16 | Outbound destination peer |
| evOutVec | output | 16 | Outbound vector |
| intrLevel | output | 1 | Pin-mode level interrupt |
| msiPulse | output | NUM_VEC | Per-vector message-interrupt pulses |

## Verification
The assertions watch properties that hold on every cycle:
- an outbound event only follows a doorbell write;
- in message mode the outbound vector always lies below the vector count;
- message pulses are one-hot and follow an inbound message-mode event;
- the level interrupt is silent in message mode;
- an idle read bus returns zero;
- the position register reads all ones before ready.

The exact register contents can only be shown by the bench, which reads them back through its own model. This covers the read-to-clear of status racing against an arriving event, the mask holding arbitrary values, and dropped out-of-range doorbells producing no event at all.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;
  localparam logic [9:0] OFF_MASK   = 10'h000;
  localparam logic [9:0] OFF_STATUS = 10'h004;
  localparam logic [9:0] OFF_POS    = 10'h008;
  localparam logic [9:0] OFF_BELL   = 10'h00C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STATUS,
    SEL_POS
  } readSel_t;

  typedef struct packed {
    logic     maskWr;
    logic     statusSet;
    logic     statusClr;
    logic     bellFire;
    logic     msiFire;
    readSel_t readSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/shm_db_ctrl.sv
module shm_db_ctrl
  import shm_db_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int ID_W    = 16
) (
  input  logic            msiMode,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [9:0]      addr,
  input  logic [ID_W-1:0] bellVec,
  input  logic            evInValid,
  input  logic [ID_W-1:0] evInVec,
  output ctrlStrobes_t    strobes
);
  localparam logic [ID_W-1:0] VEC_LIMIT = ID_W'(NUM_VEC);

  logic hitMask, hitStatus, hitPos, hitBell;

  always_comb begin
    hitMask   = (addr == OFF_MASK);
    hitStatus = (addr == OFF_STATUS);
    hitPos    = (addr == OFF_POS);
    hitBell   = (addr == OFF_BELL);

    strobes.maskWr    = wrEn && hitMask;
    strobes.statusSet = evInValid && !msiMode;
    strobes.statusClr = rdEn && hitStatus;
    strobes.bellFire  = wrEn && hitBell && (!msiMode || (bellVec < VEC_LIMIT));
    strobes.msiFire   = evInValid && msiMode && (evInVec < VEC_LIMIT);

    if (!rdEn)          strobes.readSel = SEL_NONE;
    else if (hitMask)   strobes.readSel = SEL_MASK;
    else if (hitStatus) strobes.readSel = SEL_STATUS;
    else if (hitPos)    strobes.readSel = SEL_POS;
    else                strobes.readSel = SEL_NONE;
  end
endmodule

// File: rtl/shm_db_datapath.sv
module shm_db_datapath
  import shm_db_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               msiMode,
  input  logic               devReady,
  input  logic [ID_W-1:0]    localId,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ID_W-1:0]    evInVec,
  output logic [DATA_W-1:0]  rdData,
  output logic               evOutValid,
  output logic [ID_W-1:0]    evOutPeer,
  output logic [ID_W-1:0]    evOutVec,
  output logic               intrLevel,
  output logic [NUM_VEC-1:0] msiPulse
);
  localparam int VEC_IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [DATA_W-1:0]  maskReg;
  logic [DATA_W-1:0]  statusReg;
  logic [NUM_VEC-1:0] msiNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg    <= '0;
      statusReg  <= '0;
      evOutValid <= 1'b0;
      evOutPeer  <= '0;
      evOutVec   <= '0;
      msiPulse   <= '0;
    end else begin
      if (strobes.maskWr) maskReg <= wrData;
      if (strobes.statusSet)      statusReg <= DATA_W'(1);
      else if (strobes.statusClr) statusReg <= '0;
      evOutValid <= strobes.bellFire;
      if (strobes.bellFire) begin
        evOutPeer <= wrData[2*ID_W-1:ID_W];
        evOutVec  <= wrData[ID_W-1:0];
      end
      msiPulse <= msiNext;
    end
  end

  always_comb begin
    msiNext = '0;
    if (strobes.msiFire) msiNext[evInVec[VEC_IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    unique case (strobes.readSel)
      SEL_MASK:   rdData = maskReg;
      SEL_STATUS: rdData = statusReg;
      SEL_POS:    rdData = devReady ? DATA_W'(localId) : '1;
      default:    rdData = '0;
    endcase
  end

  assign intrLevel = !msiMode && maskReg[0] && statusReg[0];
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msiMode,
  input  logic               devReady,
  input  logic [ID_W-1:0]    localId,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [9:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               evInValid,
  input  logic [ID_W-1:0]    evInVec,
  output logic               evOutValid,
  output logic [ID_W-1:0]    evOutPeer,
  output logic [ID_W-1:0]    evOutVec,
  output logic               intrLevel,
  output logic [NUM_VEC-1:0] msiPulse
);
  ctrlStrobes_t strobes;

  shm_db_ctrl #(.NUM_VEC(NUM_VEC), .ID_W(ID_W)) u_ctrl (
    .msiMode  (msiMode),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .bellVec  (wrData[ID_W-1:0]),
    .evInValid(evInValid),
    .evInVec  (evInVec),
    .strobes  (strobes)
  );

  shm_db_datapath #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .ID_W(ID_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .msiMode   (msiMode),
    .devReady  (devReady),
    .localId   (localId),
    .wrData    (wrData),
    .evInVec   (evInVec),
    .rdData    (rdData),
    .evOutValid(evOutValid),
    .evOutPeer (evOutPeer),
    .evOutVec  (evOutVec),
    .intrLevel (intrLevel),
    .msiPulse  (msiPulse)
  );
endmodule

// File: rtl/shm_db_checker.sv
module shm_db_checker #(
  parameter int NUM_VEC = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               msiMode,
  input logic               devReady,
  input logic               wrEn,
  input logic               rdEn,
  input logic [9:0]         addr,
  input logic [DATA_W-1:0]  rdData,
  input logic               evInValid,
  input logic               evOutValid,
  input logic [ID_W-1:0]    evOutVec,
  input logic               intrLevel,
  input logic [NUM_VEC-1:0] msiPulse
);
  localparam logic [ID_W-1:0] VEC_LIMIT = ID_W'(NUM_VEC);

  // R7: an outbound event only follows a doorbell write
  assert_bell_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    evOutValid |-> ($past(wrEn) && $past(addr) == 10'h00C));

  // R9: message-mode outbound vectors stay in range
  assert_bell_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evOutValid && $past(msiMode)) |-> (evOutVec < VEC_LIMIT));

  // R10: at most one message vector per cycle
  assert_msi_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(msiPulse));

  // R11: a pulse needs a message-mode inbound event
  assert_msi_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (msiPulse != '0) |-> ($past(evInValid) && $past(msiMode)));

  // R4: level interrupt silent in message mode
  assert_no_level_in_msi_R4: assert property (@(posedge clk) disable iff (!rstN)
    msiMode |-> !intrLevel);

  // R6: identifier reads all ones before ready
  assert_pos_unready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 10'h008 && !devReady) |-> (rdData == '1));

  // R1: idle read bus returns zero
  assert_idle_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));
endmodule

bind shm_doorbell_regs shm_db_checker #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .msiMode   (msiMode),
  .devReady  (devReady),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .evInValid (evInValid),
  .evOutValid(evOutValid),
  .evOutVec  (evOutVec),
  .intrLevel (intrLevel),
  .msiPulse  (msiPulse)
);

// File: tb/tb_shm_doorbell_regs.sv
module tb_shm_doorbell_regs;
  localparam int NUM_VEC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msiMode = 1'b0, devReady = 1'b0;
  logic [15:0] localId = 16'h02A5;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic evInValid = 1'b0;
  logic [15:0] evInVec = '0;
  logic evOutValid;
  logic [15:0] evOutPeer, evOutVec;
  logic intrLevel;
  logic [NUM_VEC-1:0] msiPulse;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  logic [31:0] mMask = '0, mStatus = '0;
  logic pOut = 0;
  logic [15:0] pPeer = '0, pVec = '0;
  logic [NUM_VEC-1:0] pMsi = '0;

  always #2.5 clk = ~clk;

  shm_doorbell_regs #(.NUM_VEC(NUM_VEC)) dut (
    .clk(clk), .rstN(rstN), .msiMode(msiMode), .devReady(devReady),
    .localId(localId), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evInValid(evInValid),
    .evInVec(evInVec), .evOutValid(evOutValid), .evOutPeer(evOutPeer),
    .evOutVec(evOutVec), .intrLevel(intrLevel), .msiPulse(msiPulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic r, input logic [9:0] a);
    if (!r) return 32'h0;
    case (a)
      10'h000: return mMask;
      10'h004: return mStatus;
      10'h008: return devReady ? {16'h0, localId} : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [9:0] a);
    case (a)
      10'h000: return "R2 mask";
      10'h004: return "R3 R5 status";
      10'h008: return "R6 position";
      10'h00C: return "R7 doorbell readback";
      default: return "R1 unused offset";
    endcase
  endfunction

  // one bus cycle: check outputs of last edge, drive, check read, advance model
  task automatic runCycle(input logic msi, input logic rdy, input logic w, input logic r,
                          input logic [9:0] a, input logic [31:0] d,
                          input logic ei, input logic [15:0] ev);
    logic expIntr;
    @(negedge clk);
    expIntr = !msiMode && mMask[0] && mStatus[0];
    check(evOutValid == pOut, "R7 R8 R9 evOutValid", 32'(evOutValid), 32'(pOut));
    if (pOut) begin
      check(evOutPeer == pPeer, "R7 evOutPeer", 32'(evOutPeer), 32'(pPeer));
      check(evOutVec == pVec, "R7 evOutVec", 32'(evOutVec), 32'(pVec));
    end
    check(msiPulse == pMsi, "R10 R11 msiPulse", 32'(msiPulse), 32'(pMsi));
    check(intrLevel == expIntr, "R4 intrLevel", 32'(intrLevel), 32'(expIntr));
    msiMode = msi; devReady = rdy; wrEn = w; rdEn = r; addr = a; wrData = d;
    evInValid = ei; evInVec = ev;
    #1;
    check(rdData == expRead(r, a), readTag(a), rdData, expRead(r, a));
    // next model state
    if (w && a == 10'h000) mMask = d;
    if (ei && !msi) mStatus = 32'h1;
    else if (r && a == 10'h004) mStatus = 32'h0;
    pOut = w && a == 10'h00C && (!msi || d[15:0] < 16'(NUM_VEC));
    pPeer = d[31:16]; pVec = d[15:0];
    pMsi = '0;
    if (ei && msi && ev < 16'(NUM_VEC)) pMsi[ev[1:0]] = 1'b1;
  endtask

  function automatic logic [9:0] pickAddr();
    case ($urandom % 6)
      0: return 10'h000;
      1: return 10'h004;
      2: return 10'h008;
      3: return 10'h00C;
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(evOutValid == 0, "R2 reset evOutValid", 32'(evOutValid), 0);
    check(msiPulse == 0, "R2 reset msiPulse", 32'(msiPulse), 0);
    check(intrLevel == 0, "R2 reset intrLevel", 32'(intrLevel), 0);
    runCycle(0, 0, 0, 1, 10'h000, 0, 0, 0);
    runCycle(0, 0, 0, 1, 10'h004, 0, 0, 0);
    // R6 not ready, write ignored
    runCycle(0, 0, 1, 0, 10'h008, 32'h1234_5678, 0, 0);
    runCycle(0, 0, 0, 1, 10'h008, 0, 0, 0);
    runCycle(0, 1, 0, 1, 10'h008, 0, 0, 0);
    // R1 unused offsets
    runCycle(0, 1, 1, 0, 10'h3FC, 32'hFFFF_FFFF, 0, 0);
    runCycle(0, 1, 0, 1, 10'h3FC, 0, 0, 0);
    runCycle(0, 1, 0, 1, 10'h002, 0, 0, 0);
    // R4 upper mask bits without bit 0
    runCycle(0, 1, 1, 0, 10'h000, 32'hFFFF_FFFE, 0, 0);
    runCycle(0, 1, 0, 0, 10'h000, 0, 1, 16'h7777);
    runCycle(0, 1, 0, 1, 10'h000, 0, 0, 0);
    runCycle(0, 1, 1, 0, 10'h000, 32'h0000_0001, 0, 0);
    runCycle(0, 1, 1, 0, 10'h004, 32'h0, 0, 0);        // R5 write to status ignored
    runCycle(0, 1, 0, 1, 10'h004, 0, 1, 16'h0);        // R5 clear racing an event
    runCycle(0, 1, 0, 1, 10'h004, 0, 0, 0);
    runCycle(0, 1, 0, 1, 10'h004, 0, 0, 0);
    // R8 pin mode doorbell with large vector
    runCycle(0, 1, 1, 0, 10'h00C, 32'hBEEF_FFFF, 0, 0);
    runCycle(0, 1, 0, 1, 10'h00C, 0, 0, 0);
    // R9 / R10 message mode corners
    runCycle(1, 1, 1, 0, 10'h00C, 32'h0003_0004, 0, 0);
    runCycle(1, 1, 1, 0, 10'h00C, 32'h0003_0003, 1, 16'h0002);
    runCycle(1, 1, 0, 0, 10'h000, 0, 1, 16'h0004);
    runCycle(1, 1, 0, 1, 10'h004, 0, 1, 16'h0000);
    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      logic msi;
      msi = ph[0];
      localId = 16'($urandom);
      for (int i = 0; i < 400; i++) begin
        logic w, r, ei;
        logic [31:0] d;
        int op;
        op = $urandom % 4;
        w = (op == 1);
        r = (op == 2);
        ei = ($urandom % 3) == 0;
        d = $urandom;
        if ($urandom % 2) d[15:0] = 16'($urandom % (NUM_VEC + 2));
        runCycle(msi, ($urandom % 8) != 0, w, r, pickAddr(), d, ei,
                 16'($urandom % (NUM_VEC + 2)));
      end
    end
    runCycle(0, 1, 0, 0, 10'h000, 0, 0, 0);
    runCycle(0, 1, 0, 0, 10'h000, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule